// File: doc/BRIEF.md
# Threshold-Gated Packet FIFO

This block is a byte-wide packet buffer that sits between a streaming producer and a streaming consumer on a MAC datapath. Each stored entry keeps one data byte together with start-of-frame, end-of-frame and error markers. Four fill thresholds are set at run time, each counted in entries:

- a start level, which decides when the consumer may begin draining a frame;
- a warning room, which drives an early flow-control warning;
- a stop room, which decides when the producer is stalled;
- a low level, which guards against running dry in the middle of a frame.

A start level of zero selects store-and-forward: a frame is only released once its last byte is stored. Any other value gives cut-through operation.

The block does not let the buffer overrun or run dry in the middle of a frame. It cuts the frame short with an error marker instead. If the producer is mid-frame, the buffer is nearly full and nothing is draining, the stored part of the frame is closed with an error entry and the rest of that frame is discarded. If the consumer is mid-frame, the level is low and the frame's end is not yet stored, the consumer gets a closing error beat and the rest of that frame is skipped. In store-and-forward mode an optional drop setting removes errored frames completely, so they never reach the consumer.

Top module: `mac_pkt_fifo`

## Requirements
- R1: After reset the producer is ready, no frame is offered to the consumer, the low-level flag is 1, and the stop flag and warning flag are both 0.
- R2: With a start level N > 0, the first byte of a frame is offered on the consumer side right after the clock edge that stores its N-th byte, or the edge that stores its end-of-frame byte if that comes first. Until then the consumer side stays idle.
- R3: With a start level of 0, nothing of a frame is offered until its end-of-frame byte is stored; the frame is offered right after that edge.
- R4: When the free room is at or below the stop room, the stop flag is 1 and the producer ready is 0, unless the producer side is discarding. Otherwise the stop flag is 0.
- R5: The warning flag is 1 exactly when the free room is strictly below the warning room.
- R6: The low-level flag is 1 exactly when the stored entry count is at or below the low level.
- R7: While a frame is being drained, if its end-of-frame is not stored and the count is at or below the low level, the consumer is idle for one cycle. It is then offered a beat with data 0x00, end=1 and error=1. The remaining bytes of that frame, through its end byte, are removed silently, and the next frame follows intact.
- R8: If the producer is mid-frame, the stop flag is 1 and no entry leaves in a cycle, an entry with data 0x00, end=1 and error=1 is appended. From then on every producer beat is accepted and thrown away until a start beat arrives while the stop flag is 0.
- R9: With a start level of 0 and the drop setting on, a frame whose end beat carries the error input, or that is cut by R8, is removed entirely and never offered.
- R10: Otherwise the error input on an end beat is stored and appears as the error output on that frame's end beat.
- R11: Thresholds and the drop setting are taken over only while no frame is being written and the consumer side is between frames. A change made mid-frame has no effect until then.
- R12: A producer beat without start that arrives outside a frame is accepted and discarded.
- R13: Bytes leave in the order written, with start and end markers kept, and the stored count never exceeds the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_start_lvl | input | $clog2(DEPTH)+1 | Start level, 0 selects store-and-forward |
| cfg_warn_room | input | $clog2(DEPTH)+1 | Free room below which the warning is raised |
| cfg_stop_room | input | $clog2(DEPTH)+1 | Free room at or below which the producer is stalled |
| cfg_low_lvl | input | $clog2(DEPTH)+1 | Low level for the underrun guard |
| cfg_drop_bad | input | 1 | Remove errored frames (store-and-forward only) |
| wr_valid | input | 1 | Producer beat valid |
| wr_sop | input | 1 | Producer beat starts a frame |
| wr_eop | input | 1 | Producer beat ends a frame |
| wr_err | input | 1 | Frame error, meaningful with wr_eop |
| wr_data | input | DW | Producer byte |
| wr_ready | output | 1 | Producer beat accepted when high with wr_valid |
| rd_valid | output | 1 | Consumer beat valid |
| rd_sop | output | 1 | Consumer beat starts a frame |
| rd_eop | output | 1 | Consumer beat ends a frame |
| rd_err | output | 1 | Frame error, with rd_eop |
| rd_data | output | DW | Consumer byte |
| rd_ready | input | 1 | Consumer takes the beat |
| almost_full | output | 1 | Stop flag |
| almost_empty | output | 1 | Low-level flag |
| room_warn | output | 1 | Warning flag |

## Verification
All flags and the start decision are registered from the next-state count, so each one is due right after the same edge that stores or removes the byte that moves it, with no further cycle. The underrun cut shows one idle consumer cycle after the level crosses, and the error beat follows on the next edge. A threshold change takes effect on the second edge after both sides become idle. The bench changes inputs 1 ns after an edge, records consumer beats and producer acceptance 3 ns later, and checks outputs just after the edge that its count of stored bytes says must move them.

// File: rtl/mac_pkt_fifo.sv
module mac_pkt_fifo #(
  parameter int DEPTH  = 1024,
  parameter int DW     = 8,
  parameter int SF_RST = 16,
  parameter int AE_RST = 8,
  parameter int AF_RST = 8,
  parameter int SE_RST = DEPTH - 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(DEPTH):0]     cfg_start_lvl,
  input  logic [$clog2(DEPTH):0]     cfg_warn_room,
  input  logic [$clog2(DEPTH):0]     cfg_stop_room,
  input  logic [$clog2(DEPTH):0]     cfg_low_lvl,
  input  logic                       cfg_drop_bad,
  input  logic                       wr_valid,
  input  logic                       wr_sop,
  input  logic                       wr_eop,
  input  logic                       wr_err,
  input  logic [DW-1:0]              wr_data,
  output logic                       wr_ready,
  output logic                       rd_valid,
  output logic                       rd_sop,
  output logic                       rd_eop,
  output logic                       rd_err,
  output logic [DW-1:0]              rd_data,
  input  logic                       rd_ready,
  output logic                       almost_full,
  output logic                       almost_empty,
  output logic                       room_warn
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int EW = DW + 3;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [CW-1:0] SF0  = CW'(SF_RST);
  localparam logic [CW-1:0] AE0  = CW'(AE_RST);
  localparam logic [CW-1:0] AF0  = CW'(AF_RST);
  localparam logic [CW-1:0] SE0  = CW'(SE_RST);

  typedef enum logic [1:0] {RD_IDLE, RD_BODY, RD_CUT, RD_SKIP} rd_st_e;

  logic [EW-1:0] mem [DEPTH];
  logic [CW-1:0] wptr, rptr, fstart, eops, cnt;
  logic [CW-1:0] thr_sf, thr_se, thr_af, thr_ae;
  logic          drop_bad_q, in_wf, drop_q;
  logic          af_q, ae_q, se_q, uf_q, start_ok_q;
  rd_st_e        rs;

  logic [EW-1:0] head, wentry;
  logic          head_sop, head_eop, head_err;
  logic          saf, saf_drop, wacc, take, bad_end, put;
  logic          ovf, ovf_go, ovf_rew, ovf_mark, wr_en;
  logic          rd_fire, pop, eop_in, eop_out, cap;
  logic [CW-1:0] rew_ptr, wptr_nx, rptr_nx, cnt_nx, eops_nx, room_nx;

  assign cnt      = wptr - rptr;
  assign head     = mem[rptr[AW-1:0]];
  assign head_sop = head[DW];
  assign head_eop = head[DW+1];
  assign head_err = head[DW+2];

  assign saf      = (thr_sf == '0);
  assign saf_drop = saf & drop_bad_q;

  // producer side
  assign wr_ready = drop_q | ~af_q;
  assign wacc     = wr_valid & wr_ready;
  assign take     = wacc & (drop_q ? (wr_sop & ~af_q) : (in_wf | wr_sop));
  assign bad_end  = take & wr_eop & wr_err & saf_drop;
  assign put      = take & ~bad_end;

  assign ovf      = in_wf & ~drop_q & af_q & ~pop;
  assign ovf_go   = ovf & (saf_drop | (cnt != FULL));
  assign ovf_rew  = ovf_go & saf_drop;
  assign ovf_mark = ovf_go & ~saf_drop;

  assign wr_en    = put | ovf_mark;
  assign wentry   = ovf_mark ? {1'b1, 1'b1, 1'b0, {DW{1'b0}}}
                             : {wr_err & wr_eop, wr_eop, wr_sop, wr_data};
  assign rew_ptr  = (take & wr_sop) ? wptr : fstart;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr[AW-1:0]] <= wentry;
  end

  // consumer side
  always_comb begin
    rd_valid = 1'b0;
    rd_sop   = head_sop;
    rd_eop   = head_eop;
    rd_err   = head_err;
    rd_data  = head[DW-1:0];
    case (rs)
      RD_IDLE: rd_valid = start_ok_q;
      RD_BODY: rd_valid = (cnt != '0) & ~uf_q;
      RD_CUT: begin
        rd_valid = 1'b1;
        rd_sop   = 1'b0;
        rd_eop   = 1'b1;
        rd_err   = 1'b1;
        rd_data  = '0;
      end
      default: rd_valid = 1'b0;
    endcase
  end

  assign rd_fire = rd_valid & rd_ready;
  assign pop     = (rd_fire & (rs != RD_CUT)) | ((rs == RD_SKIP) & (cnt != '0));

  // next-state level bookkeeping
  assign eop_in  = wr_en & (ovf_mark | wr_eop);
  assign eop_out = pop & head_eop;
  assign wptr_nx = (bad_end | ovf_rew) ? rew_ptr : wptr + CW'(wr_en);
  assign rptr_nx = rptr + CW'(pop);
  assign cnt_nx  = wptr_nx - rptr_nx;
  assign eops_nx = eops + CW'(eop_in) - CW'(eop_out);
  assign room_nx = FULL - cnt_nx;
  assign cap     = ~in_wf & (rs == RD_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr       <= '0;
      rptr       <= '0;
      fstart     <= '0;
      eops       <= '0;
      in_wf      <= 1'b0;
      drop_q     <= 1'b0;
      thr_sf     <= SF0;
      thr_se     <= SE0;
      thr_af     <= AF0;
      thr_ae     <= AE0;
      drop_bad_q <= 1'b0;
      af_q       <= (FULL <= AF0);
      se_q       <= (FULL < SE0);
      ae_q       <= 1'b1;
      uf_q       <= 1'b1;
      start_ok_q <= 1'b0;
    end else begin
      wptr <= wptr_nx;
      rptr <= rptr_nx;
      eops <= eops_nx;
      if (take & wr_sop) fstart <= wptr;
      if (ovf_go) begin
        in_wf  <= 1'b0;
        drop_q <= 1'b1;
      end else if (take) begin
        in_wf  <= ~wr_eop;
        drop_q <= 1'b0;
      end
      if (cap) begin
        thr_sf     <= cfg_start_lvl;
        thr_se     <= cfg_warn_room;
        thr_af     <= cfg_stop_room;
        thr_ae     <= cfg_low_lvl;
        drop_bad_q <= cfg_drop_bad;
      end
      af_q       <= room_nx <= thr_af;
      se_q       <= room_nx < thr_se;
      ae_q       <= cnt_nx <= thr_ae;
      uf_q       <= (eops_nx == '0) & (cnt_nx <= thr_ae);
      start_ok_q <= (cnt_nx != '0) &
                    ((eops_nx != '0) | ((thr_sf != '0) & (cnt_nx >= thr_sf)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs <= RD_IDLE;
    end else begin
      case (rs)
        RD_IDLE: if (rd_fire && !head_eop) rs <= RD_BODY;
        RD_BODY: begin
          if (uf_q)                      rs <= RD_CUT;
          else if (rd_fire && head_eop)  rs <= RD_IDLE;
        end
        RD_CUT:  if (rd_ready) rs <= RD_SKIP;
        default: if (pop && head_eop) rs <= RD_IDLE;
      endcase
    end
  end

  assign almost_full  = af_q;
  assign almost_empty = ae_q;
  assign room_warn    = se_q;

  // R4
  full_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == FULL && !drop_q) |-> !wr_ready);

  // R13
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);

  // R7
  cut_then_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs == RD_CUT && rd_ready) |=> !rd_valid);

  // R3
  saf_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs == RD_IDLE && rd_valid && thr_sf == '0) |-> (eops != '0));

  // R12
  stray_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_wf && !drop_q && wr_valid && wr_ready && !wr_sop) |=> $stable(wptr));

  // R2
  start_sop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs == RD_IDLE && rd_valid) |-> rd_sop);

endmodule

// File: tb/mac_pkt_fifo_test.sv
module mac_pkt_fifo_test;
  localparam int DEPTH = 64;
  localparam int CW = $clog2(DEPTH) + 1;
  localparam logic [15:0] VEC [8] = '{
    {8'd16, 8'd30}, {8'd16, 8'd10}, {8'd0, 8'd20}, {8'd4, 8'd4},
    {8'd1, 8'd1},   {8'd0, 8'd1},   {8'd8, 8'd40}, {8'd20, 8'd25}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] cfg_sf = CW'(16), cfg_se = CW'(48), cfg_af = CW'(8), cfg_ae = CW'(8);
  logic cfg_drop = 1'b0;
  logic wr_valid = 1'b0, wr_sop = 1'b0, wr_eop = 1'b0, wr_err = 1'b0;
  logic [7:0] wr_data = '0;
  logic rd_ready = 1'b0;
  logic wr_ready, rd_valid, rd_sop, rd_eop, rd_err, almost_full, almost_empty, room_warn;
  logic [7:0] rd_data;

  int nchk = 0, nfail = 0, ncap = 0;
  bit wacc, done = 1'b0;
  logic [7:0] cd [256];
  logic cs [256], ce [256], cr [256];

  mac_pkt_fifo #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_start_lvl(cfg_sf), .cfg_warn_room(cfg_se), .cfg_stop_room(cfg_af),
    .cfg_low_lvl(cfg_ae), .cfg_drop_bad(cfg_drop),
    .wr_valid(wr_valid), .wr_sop(wr_sop), .wr_eop(wr_eop), .wr_err(wr_err),
    .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_valid(rd_valid), .rd_sop(rd_sop), .rd_eop(rd_eop), .rd_err(rd_err),
    .rd_data(rd_data), .rd_ready(rd_ready),
    .almost_full(almost_full), .almost_empty(almost_empty), .room_warn(room_warn)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    #3;
    if (rd_valid && rd_ready && ncap < 256) begin
      cd[ncap] = rd_data; cs[ncap] = rd_sop; ce[ncap] = rd_eop; cr[ncap] = rd_err;
      ncap++;
    end
    wacc = wr_valid && wr_ready;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic send(input logic [7:0] d, input bit s, input bit e, input bit er);
    int g;
    wr_valid = 1'b1; wr_data = d; wr_sop = s; wr_eop = e; wr_err = er;
    g = 0;
    do begin step(); g++; end while (!wacc && g < 500);
    wr_valid = 1'b0; wr_sop = 1'b0; wr_eop = 1'b0; wr_err = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int firstv, expv, len, sf;
    bit good;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk(wr_ready == 1'b1, "R1 wr_ready", wr_ready, 1);
    chk(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
    chk(almost_empty == 1'b1, "R1 almost_empty", almost_empty, 1);
    chk(almost_full == 1'b0, "R1 almost_full", almost_full, 0);
    chk(room_warn == 1'b0, "R1 room_warn", room_warn, 0);

    // vector table: start level and frame length, R2 / R3 / R13
    for (int v = 0; v < 8; v++) begin
      sf = int'(VEC[v][15:8]);
      len = int'(VEC[v][7:0]);
      cfg_sf = CW'(sf);
      rd_ready = 1'b0;
      idle(2);
      firstv = 0;
      for (int i = 0; i < len; i++) begin
        send(8'(v * 16 + i), i == 0, i == len - 1, 1'b0);
        if (rd_valid && firstv == 0) firstv = i + 1;
      end
      expv = (sf == 0 || sf > len) ? len : sf;
      chk(firstv == expv, sf == 0 ? "R3 start point" : "R2 start point", firstv, expv);
      ncap = 0;
      rd_ready = 1'b1;
      idle(len + 10);
      rd_ready = 1'b0;
      good = (ncap == len);
      for (int i = 0; i < len && good; i++)
        if (cd[i] != 8'(v * 16 + i) || cs[i] != (i == 0) || ce[i] != (i == len - 1) || cr[i])
          good = 1'b0;
      chk(good, "R13 frame order", ncap, len);
    end

    // flags with single-beat frames, store-and-forward: R4 R5 R6
    cfg_sf = '0;
    idle(2);
    for (int k = 0; k < 56; k++) begin
      send(8'(k), 1'b1, 1'b1, 1'b0);
      if (k + 1 == 8)  chk(almost_empty == 1'b1, "R6 at low level", almost_empty, 1);
      if (k + 1 == 9)  chk(almost_empty == 1'b0, "R6 above low level", almost_empty, 0);
      if (k + 1 == 16) chk(room_warn == 1'b0, "R5 room 48", room_warn, 0);
      if (k + 1 == 17) chk(room_warn == 1'b1, "R5 room 47", room_warn, 1);
      if (k + 1 == 55) begin
        chk(almost_full == 1'b0, "R4 room 9 flag", almost_full, 0);
        chk(wr_ready == 1'b1, "R4 room 9 ready", wr_ready, 1);
      end
    end
    chk(almost_full == 1'b1, "R4 room 8 flag", almost_full, 1);
    chk(wr_ready == 1'b0, "R4 room 8 ready", wr_ready, 0);
    ncap = 0;
    rd_ready = 1'b1;
    idle(70);
    rd_ready = 1'b0;
    good = (ncap == 56);
    for (int i = 0; i < 56 && good; i++)
      if (cd[i] != 8'(i) || !cs[i] || !ce[i]) good = 1'b0;
    chk(good, "R13 single-beat frames", ncap, 56);

    // R12 stray beat outside a frame
    send(8'hEE, 1'b0, 1'b1, 1'b0);
    idle(2);
    chk(rd_valid == 1'b0, "R12 stray beat stored", rd_valid, 0);

    // R9 errored frame removed in store-and-forward with drop on
    cfg_drop = 1'b1;
    idle(2);
    send(8'h31, 1'b1, 1'b0, 1'b0);
    send(8'h32, 1'b0, 1'b0, 1'b0);
    send(8'h33, 1'b0, 1'b1, 1'b1);
    idle(2);
    chk(rd_valid == 1'b0, "R9 bad frame offered", rd_valid, 0);
    send(8'h41, 1'b1, 1'b0, 1'b0);
    send(8'h42, 1'b0, 1'b1, 1'b0);
    ncap = 0;
    rd_ready = 1'b1;
    idle(6);
    rd_ready = 1'b0;
    chk(ncap == 2 && cd[0] == 8'h41 && cd[1] == 8'h42, "R9 next frame", ncap, 2);
    cfg_drop = 1'b0;

    // R10 error passes through in cut-through
    cfg_sf = CW'(4);
    idle(2);
    send(8'h51, 1'b1, 1'b0, 1'b0);
    send(8'h52, 1'b0, 1'b0, 1'b0);
    send(8'h53, 1'b0, 1'b1, 1'b1);
    ncap = 0;
    rd_ready = 1'b1;
    idle(6);
    rd_ready = 1'b0;
    chk(ncap == 3 && ce[2] && cr[2] && cd[2] == 8'h53, "R10 error on end beat", ncap, 3);
    chk(ncap == 3 && !cr[0] && !cr[1], "R10 error only at end", ncap, 3);

    // R11 thresholds held while a frame is open
    cfg_sf = '0;
    idle(2);
    send(8'h61, 1'b1, 1'b0, 1'b0);
    send(8'h62, 1'b0, 1'b0, 1'b0);
    cfg_sf = CW'(1);
    idle(3);
    chk(rd_valid == 1'b0, "R11 mid-frame change", rd_valid, 0);
    send(8'h63, 1'b0, 1'b1, 1'b0);
    rd_ready = 1'b1;
    idle(6);
    rd_ready = 1'b0;
    idle(2);
    send(8'h71, 1'b1, 1'b0, 1'b0);
    chk(rd_valid == 1'b1, "R11 taken between frames", rd_valid, 1);
    send(8'h72, 1'b0, 1'b1, 1'b0);
    rd_ready = 1'b1;
    idle(6);
    rd_ready = 1'b0;

    // R7 underrun guard
    cfg_sf = CW'(4);
    cfg_ae = CW'(2);
    idle(2);
    for (int i = 0; i < 6; i++) send(8'h80 + 8'(i), i == 0, 1'b0, 1'b0);
    ncap = 0;
    rd_ready = 1'b1;
    idle(10);
    chk(ncap == 5, "R7 beats before cut", ncap, 5);
    chk(cd[3] == 8'h83 && ce[4] && cr[4] && cd[4] == 8'h00 && !ce[3], "R7 cut beat",
        {cd[4], 3'b0, ce[4], 3'b0, cr[4]}, 16'h0011);
    send(8'h86, 1'b0, 1'b0, 1'b0);
    send(8'h87, 1'b0, 1'b1, 1'b0);
    send(8'h90, 1'b1, 1'b0, 1'b0);
    send(8'h91, 1'b0, 1'b1, 1'b0);
    idle(8);
    chk(ncap == 7 && cd[5] == 8'h90 && cs[5] && cd[6] == 8'h91 && ce[6] && !cr[6],
        "R7 next frame intact", ncap, 7);
    rd_ready = 1'b0;
    cfg_ae = CW'(8);

    // R8 overrun guard in cut-through
    cfg_sf = CW'(16);
    idle(2);
    for (int i = 0; i < 56; i++) send(8'(i), i == 0, 1'b0, 1'b0);
    chk(wr_ready == 1'b0 && almost_full == 1'b1, "R8 stalled at stop room", wr_ready, 0);
    idle(1);
    chk(wr_ready == 1'b1, "R8 discard after cut", wr_ready, 1);
    for (int i = 0; i < 3; i++) send(8'hAA, 1'b0, 1'b0, 1'b0);
    ncap = 0;
    rd_ready = 1'b1;
    idle(70);
    chk(ncap == 57, "R8 stored beats", ncap, 57);
    chk(ncap == 57 && cd[55] == 8'd55 && cd[56] == 8'h00 && ce[56] && cr[56] && !ce[55],
        "R8 closing entry", cd[56], 0);
    send(8'hB0, 1'b1, 1'b0, 1'b0);
    send(8'hB1, 1'b0, 1'b1, 1'b0);
    idle(6);
    rd_ready = 1'b0;
    chk(ncap == 59 && cd[57] == 8'hB0 && cs[57] && cd[58] == 8'hB1 && ce[58],
        "R8 resumes on start beat", ncap, 59);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule